// File: doc/BRIEF.md
# Vector Lane Predicate Mask Unit

This unit decides which byte lanes of a 128-bit, four-beat vector instruction are allowed to write their results. It combines three masking sources into one 16-bit lane mask, where a 1 lets a lane write and a 0 suppresses it. The sources are the per-lane predicate bits, gated by two 4-bit half-mask fields. A tail-predication limit on the final loop pass trims the mask. A beat-skip code marks beats that already completed before a resumed instruction, and those beats are cleared.

The lane mask is purely combinational. When the instruction retires, an advance strobe clocks the successor predicate state and the successor beat-skip code into output registers. These registers hold the predicate bits, the two half-mask fields and the beat-skip code. The successor predicate state steps like a vector if-then block: a half whose mask field shows a then/else transition has its eight predicate bits inverted, and each field then shifts left by one. Element widths are read from the one mask: byte elements use every bit, halfword elements use bits 0, 2, … 14, and word elements use bits 0, 4, 8 and 12.

Top module: `lane_pred_unit`

## Requirements
- R1: When both half-mask fields are nonzero, tail predication is off (size code 4 or more) and the beat-skip qualifier is nonzero, `lane_mask_o` equals `pred_bits_i` exactly.
- R2: A zero low-half field (`lo_fld_i`) forces mask bits 7:0 to 1; a zero high-half field (`hi_fld_i`) forces mask bits 15:8 to 1.
- R3: When `tail_size_i` < 4 and `loop_cnt_i` <= 1<<(4 − `tail_size_i`), the mask is ANDed with a run of (`loop_cnt_i` << `tail_size_i`) ones starting at bit 0. A count of 0 gives an all-zero mask.
- R4: When `tail_size_i` >= 4, or when the count exceeds that limit, the tail stage leaves the mask unchanged.
- R5: Beat-skip masking acts only when `cond_lo_i` is 0. Skip codes are 0 none, 1 first beat done, 2 two beats done, 3 three beats done, 4 three beats plus one beat of the next instruction done. Code 1 clears bits 3:0, code 2 clears bits 7:0, and codes 3 and 4 clear bits 11:0. Code 0 changes nothing.
- R6: With `cond_lo_i` = 0, skip codes 5 to 7 are illegal. They raise `skip_err_o` and leave the mask unchanged. `skip_err_o` is 0 in every other case.
- R7: On advance with `cond_lo_i` = 0, the stored skip code becomes 0, except that code 4 becomes 1. With `cond_lo_i` nonzero, the input code is stored unchanged.
- R8: On advance with both half-mask fields zero, the predicate bits and both fields are stored unchanged.
- R9: On advance, each half whose field exceeds 8 has its eight predicate bits inverted. Each field is then stored shifted left by one and truncated to 4 bits.
- R10: Without advance, the stored state holds its value.
- R11: An active-low asynchronous reset clears all stored state to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pred_bits_i | input | 16 | Per-byte-lane predicate bits |
| lo_fld_i | input | 4 | Low-half mask field |
| hi_fld_i | input | 4 | High-half mask field |
| tail_size_i | input | 3 | Tail element-size code (log2 bytes); 4 or more disables |
| loop_cnt_i | input | CNT_W | Remaining loop element count |
| cond_lo_i | input | 4 | Low nibble of condition state; zero qualifies the skip code |
| skip_code_i | input | 3 | Beat-skip code |
| advance_i | input | 1 | Instruction retire strobe |
| lane_mask_o | output | 16 | Byte-lane write mask |
| skip_err_o | output | 1 | Illegal beat-skip code flag |
| pred_bits_o | output | 16 | Stored successor predicate bits |
| lo_fld_o | output | 4 | Stored successor low-half field |
| hi_fld_o | output | 4 | Stored successor high-half field |
| skip_code_o | output | 3 | Stored successor beat-skip code |

## Verification
On every cycle the assertions check several properties. The tail stage never sets a lane that the predicate stage cleared. A zero half field yields ones in that half. An unqualified or illegal skip code leaves the mask untouched. State holds without advance, and code 4 steps to 1. An advance with both fields zero is a copy, and a low field above 8 inverts the low byte. Only the bench's scenarios show the exact tail run length at each element size and the count boundary where tailing switches off. The same holds for the exact beats each skip code clears and the combined effect of all three stages at once, which the bench compares lane by lane against its own model.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int unsigned LANES = 16;
  localparam int unsigned FLD_W = 4;
  localparam int unsigned CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    SKIP_NONE  = 3'd0,
    SKIP_B1    = 3'd1,
    SKIP_B2    = 3'd2,
    SKIP_B3    = 3'd3,
    SKIP_B3_N1 = 3'd4
  } skip_e;
endpackage

// File: rtl/lpm_base_mask.sv
module lpm_base_mask #(
  parameter int unsigned LANES = lpm_pkg::LANES,
  parameter int unsigned FLD_W = lpm_pkg::FLD_W
) (
  input  logic [LANES-1:0] pred_i,
  input  logic [FLD_W-1:0] lo_fld_i,
  input  logic [FLD_W-1:0] hi_fld_i,
  output logic [LANES-1:0] base_o
);
  localparam int unsigned HALF = LANES / 2;

  logic [1:0][FLD_W-1:0] fld;
  assign fld[0] = lo_fld_i;
  assign fld[1] = hi_fld_i;

  for (genvar h = 0; h < 2; h++) begin : g_half
    // an idle half is fully enabled
    assign base_o[h*HALF +: HALF] = (fld[h] == '0) ? {HALF{1'b1}} : pred_i[h*HALF +: HALF];
  end
endmodule

// File: rtl/lpm_tail_mask.sv
module lpm_tail_mask #(
  parameter int unsigned LANES = lpm_pkg::LANES,
  parameter int unsigned CNT_W = 32
) (
  input  logic [LANES-1:0] mask_i,
  input  logic [2:0]       size_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [LANES-1:0] mask_o
);
  localparam int unsigned LEN_W = $clog2(LANES) + 1;

  logic             tail_on;
  logic [CNT_W-1:0] limit;
  logic [LEN_W-1:0] run_len;

  always_comb begin
    limit   = '0;
    run_len = '0;
    tail_on = 1'b0;
    if (size_i < 3'd4) begin
      limit   = CNT_W'(LANES) >> size_i[1:0];
      tail_on = (cnt_i <= limit);
      // count <= LANES>>size, so the run never exceeds LANES
      run_len = cnt_i[LEN_W-1:0] << size_i[1:0];
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mask_o[i] = mask_i[i] & (~tail_on | (LEN_W'(i) < run_len));
  end
endmodule

// File: rtl/lpm_skip_mask.sv
module lpm_skip_mask #(
  parameter int unsigned LANES  = lpm_pkg::LANES,
  parameter int unsigned CODE_W = lpm_pkg::CODE_W
) (
  input  logic [LANES-1:0]  mask_i,
  input  logic [3:0]        cond_lo_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [LANES-1:0]  mask_o,
  output logic              err_o
);
  import lpm_pkg::*;
  localparam int unsigned BEATS  = 4;
  localparam int unsigned BEAT_W = LANES / BEATS;

  logic       qual;
  logic [2:0] done_beats;

  assign qual = (cond_lo_i == 4'd0);

  always_comb begin
    done_beats = 3'd0;
    err_o      = 1'b0;
    if (qual) begin
      unique case (code_i)
        SKIP_NONE:             done_beats = 3'd0;
        SKIP_B1:               done_beats = 3'd1;
        SKIP_B2:               done_beats = 3'd2;
        SKIP_B3, SKIP_B3_N1:   done_beats = 3'd3;
        default:               err_o      = 1'b1;
      endcase
    end
  end

  for (genvar b = 0; b < BEATS; b++) begin : g_beat
    assign mask_o[b*BEAT_W +: BEAT_W] =
      mask_i[b*BEAT_W +: BEAT_W] & {BEAT_W{(3'(b) >= done_beats)}};
  end
endmodule

// File: rtl/lpm_pred_adv.sv
module lpm_pred_adv #(
  parameter int unsigned LANES  = lpm_pkg::LANES,
  parameter int unsigned FLD_W  = lpm_pkg::FLD_W,
  parameter int unsigned CODE_W = lpm_pkg::CODE_W
) (
  input  logic [LANES-1:0]  pred_i,
  input  logic [FLD_W-1:0]  lo_fld_i,
  input  logic [FLD_W-1:0]  hi_fld_i,
  input  logic [3:0]        cond_lo_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [LANES-1:0]  pred_o,
  output logic [FLD_W-1:0]  lo_fld_o,
  output logic [FLD_W-1:0]  hi_fld_o,
  output logic [CODE_W-1:0] code_o
);
  import lpm_pkg::*;
  localparam int unsigned HALF = LANES / 2;
  localparam logic [FLD_W-1:0] FLD_MID = FLD_W'(1) << (FLD_W - 1);

  logic                  vpt_on;
  logic [1:0][FLD_W-1:0] fld_in, fld_out;

  assign fld_in[0] = lo_fld_i;
  assign fld_in[1] = hi_fld_i;
  assign vpt_on    = (lo_fld_i != '0) || (hi_fld_i != '0);

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic flip;
    // top bit set with a lower bit set marks a then/else transition
    assign flip = vpt_on && (fld_in[h] > FLD_MID);
    assign pred_o[h*HALF +: HALF] = pred_i[h*HALF +: HALF] ^ {HALF{flip}};
    assign fld_out[h] = vpt_on ? (fld_in[h] << 1) : fld_in[h];
  end

  assign lo_fld_o = fld_out[0];
  assign hi_fld_o = fld_out[1];

  always_comb begin
    code_o = code_i;
    if (cond_lo_i == 4'd0)
      code_o = (code_i == SKIP_B3_N1) ? SKIP_B1 : SKIP_NONE;
  end
endmodule

// File: rtl/lane_pred_unit.sv
module lane_pred_unit #(
  parameter int unsigned LANES  = lpm_pkg::LANES,
  parameter int unsigned FLD_W  = lpm_pkg::FLD_W,
  parameter int unsigned CODE_W = lpm_pkg::CODE_W,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LANES-1:0]  pred_bits_i,
  input  logic [FLD_W-1:0]  lo_fld_i,
  input  logic [FLD_W-1:0]  hi_fld_i,
  input  logic [2:0]        tail_size_i,
  input  logic [CNT_W-1:0]  loop_cnt_i,
  input  logic [3:0]        cond_lo_i,
  input  logic [CODE_W-1:0] skip_code_i,
  input  logic              advance_i,
  output logic [LANES-1:0]  lane_mask_o,
  output logic              skip_err_o,
  output logic [LANES-1:0]  pred_bits_o,
  output logic [FLD_W-1:0]  lo_fld_o,
  output logic [FLD_W-1:0]  hi_fld_o,
  output logic [CODE_W-1:0] skip_code_o
);
  localparam int unsigned HALF = LANES / 2;

  logic [LANES-1:0]  base_mask, tail_mask;
  logic [LANES-1:0]  pred_d, pred_q;
  logic [FLD_W-1:0]  lo_d, lo_q, hi_d, hi_q;
  logic [CODE_W-1:0] code_d, code_q;

  lpm_base_mask #(.LANES(LANES), .FLD_W(FLD_W)) u_base (
    .pred_i   (pred_bits_i),
    .lo_fld_i (lo_fld_i),
    .hi_fld_i (hi_fld_i),
    .base_o   (base_mask)
  );

  lpm_tail_mask #(.LANES(LANES), .CNT_W(CNT_W)) u_tail (
    .mask_i (base_mask),
    .size_i (tail_size_i),
    .cnt_i  (loop_cnt_i),
    .mask_o (tail_mask)
  );

  lpm_skip_mask #(.LANES(LANES), .CODE_W(CODE_W)) u_skip (
    .mask_i    (tail_mask),
    .cond_lo_i (cond_lo_i),
    .code_i    (skip_code_i),
    .mask_o    (lane_mask_o),
    .err_o     (skip_err_o)
  );

  lpm_pred_adv #(.LANES(LANES), .FLD_W(FLD_W), .CODE_W(CODE_W)) u_adv (
    .pred_i    (pred_bits_i),
    .lo_fld_i  (lo_fld_i),
    .hi_fld_i  (hi_fld_i),
    .cond_lo_i (cond_lo_i),
    .code_i    (skip_code_i),
    .pred_o    (pred_d),
    .lo_fld_o  (lo_d),
    .hi_fld_o  (hi_d),
    .code_o    (code_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      code_q <= '0;
    end else if (advance_i) begin
      pred_q <= pred_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      code_q <= code_d;
    end
  end

  assign pred_bits_o = pred_q;
  assign lo_fld_o    = lo_q;
  assign hi_fld_o    = hi_q;
  assign skip_code_o = code_q;

  // mask stage checks
  p_force_lo_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_fld_i == '0) |-> (base_mask[HALF-1:0] == {HALF{1'b1}}));

  p_force_hi_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_fld_i == '0) |-> (base_mask[LANES-1:HALF] == {HALF{1'b1}}));

  p_tail_subset_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((tail_mask & ~base_mask) == '0));

  p_tail_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tail_size_i >= 3'd4) |-> (tail_mask == base_mask));

  p_skip_unqual_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_lo_i != 4'd0) |-> (lane_mask_o == tail_mask && !skip_err_o));

  p_err_noeffect_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_err_o |-> (lane_mask_o == tail_mask));

  // state update checks
  p_skip_resume_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && cond_lo_i == 4'd0 && skip_code_i == 3'd4) |=> (skip_code_o == 3'd1));

  p_idle_copy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && lo_fld_i == '0 && hi_fld_i == '0) |=>
      (pred_bits_o == $past(pred_bits_i) && lo_fld_o == '0 && hi_fld_o == '0));

  p_flip_lo_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && lo_fld_i > FLD_W'(8)) |=>
      (pred_bits_o[HALF-1:0] == ~$past(pred_bits_i[HALF-1:0])));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !advance_i |=> ($stable(pred_bits_o) && $stable(lo_fld_o) &&
                    $stable(hi_fld_o) && $stable(skip_code_o)));
endmodule

// File: tb/lane_pred_unit_tb.sv
`timescale 1ns/1ps
module lane_pred_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pred = '0;
  logic [3:0]  lo = '0, hi = '0;
  logic [2:0]  sz = 3'd4;
  logic [31:0] cnt = '0;
  logic [3:0]  cl = 4'd1;
  logic [2:0]  cd = '0;
  logic        adv = 1'b0;
  logic [15:0] mask_o, pred_o;
  logic        err_o;
  logic [3:0]  lo_o, hi_o;
  logic [2:0]  code_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // expected stored state and pending successor
  logic [15:0] ex_pred = '0, pn_pred = '0;
  logic [3:0]  ex_lo = '0, ex_hi = '0, pn_lo = '0, pn_hi = '0;
  logic [2:0]  ex_code = '0, pn_code = '0;
  bit          pn_adv = 0;
  string       pn_tag = "R11";

  always #2.5 clk = ~clk;

  lane_pred_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pred_bits_i(pred), .lo_fld_i(lo), .hi_fld_i(hi),
    .tail_size_i(sz), .loop_cnt_i(cnt), .cond_lo_i(cl), .skip_code_i(cd),
    .advance_i(adv), .lane_mask_o(mask_o), .skip_err_o(err_o), .pred_bits_o(pred_o),
    .lo_fld_o(lo_o), .hi_fld_o(hi_o), .skip_code_o(code_o)
  );

  task automatic chk(string tag, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mdl_mask(logic [15:0] p, logic [3:0] l, logic [3:0] h,
                                           logic [2:0] s, logic [31:0] c,
                                           logic [3:0] q, logic [2:0] k);
    logic [15:0] m = p;
    if (l == 0) m[7:0] = 8'hff;
    if (h == 0) m[15:8] = 8'hff;
    if (s < 4 && longint'(c) <= (longint'(16) >> s)) begin
      int len = int'(c) << s;
      for (int i = 0; i < 16; i++) if (i >= len) m[i] = 1'b0;
    end
    if (q == 0) begin
      case (k)
        3'd1: m = m & 16'hfff0;
        3'd2: m = m & 16'hff00;
        3'd3, 3'd4: m = m & 16'hf000;
        default: ;
      endcase
    end
    return m;
  endfunction

  task automatic step(logic [15:0] p, logic [3:0] l, logic [3:0] h, logic [2:0] s,
                      logic [31:0] c, logic [3:0] q, logic [2:0] k, bit a, string tag);
    @(negedge clk);
    if (pn_adv) begin
      ex_pred = pn_pred; ex_lo = pn_lo; ex_hi = pn_hi; ex_code = pn_code;
    end
    chk(pn_tag, "pred_bits", pred_o, ex_pred);
    chk(pn_tag, "lo_fld", lo_o, ex_lo);
    chk(pn_tag, "hi_fld", hi_o, ex_hi);
    chk(pn_tag, "skip_code", code_o, ex_code);
    pred = p; lo = l; hi = h; sz = s; cnt = c; cl = q; cd = k; adv = a;
    #1;
    chk(tag, "lane_mask", mask_o, mdl_mask(p, l, h, s, c, q, k));
    chk(tag, "skip_err", err_o, (q == 0 && k > 4));
    pn_adv = a; pn_tag = tag;
    if (a) begin
      pn_pred = p; pn_lo = l; pn_hi = h;
      if (l != 0 || h != 0) begin
        if (l > 8) pn_pred[7:0] = ~p[7:0];
        if (h > 8) pn_pred[15:8] = ~p[15:8];
        pn_lo = 4'((l * 2) % 16);
        pn_hi = 4'((h * 2) % 16);
      end
      pn_code = (q != 0) ? k : ((k == 4) ? 3'd1 : 3'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset clears state
    chk("R11", "pred_bits", pred_o, 0);
    chk("R11", "lo_fld", lo_o, 0);
    chk("R11", "hi_fld", hi_o, 0);
    chk("R11", "skip_code", code_o, 0);
    rst_n = 1'b1;
    step(16'ha5c3, 4'd1, 4'd1, 3'd4, 32'd0, 4'd1, 3'd0, 0, "R1");
    step(16'h1234, 4'd0, 4'd3, 3'd4, 32'd0, 4'd1, 3'd0, 0, "R2");
    step(16'h1234, 4'd2, 4'd0, 3'd4, 32'd0, 4'd1, 3'd0, 0, "R2");
    step(16'h0000, 4'd0, 4'd0, 3'd0, 32'd5, 4'd1, 3'd0, 0, "R3");
    step(16'h0000, 4'd0, 4'd0, 3'd1, 32'd3, 4'd1, 3'd0, 0, "R3");
    step(16'h0000, 4'd0, 4'd0, 3'd2, 32'd2, 4'd1, 3'd0, 0, "R3");
    step(16'h0000, 4'd0, 4'd0, 3'd2, 32'd0, 4'd1, 3'd0, 0, "R3");
    step(16'h0000, 4'd0, 4'd0, 3'd3, 32'd2, 4'd1, 3'd0, 0, "R3");
    step(16'h0000, 4'd0, 4'd0, 3'd0, 32'd16, 4'd1, 3'd0, 0, "R3");
    step(16'h0000, 4'd0, 4'd0, 3'd2, 32'd5, 4'd1, 3'd0, 0, "R4");
    step(16'h0000, 4'd0, 4'd0, 3'd0, 32'd17, 4'd1, 3'd0, 0, "R4");
    step(16'h0000, 4'd0, 4'd0, 3'd4, 32'd1, 4'd1, 3'd0, 0, "R4");
    for (int k = 0; k < 5; k++)
      step(16'h0000, 4'd0, 4'd0, 3'd4, 32'd0, 4'd0, 3'(k), 0, "R5");
    step(16'h0000, 4'd0, 4'd0, 3'd4, 32'd0, 4'd2, 3'd3, 0, "R5");
    step(16'h0000, 4'd0, 4'd0, 3'd4, 32'd0, 4'd0, 3'd6, 0, "R6");
    step(16'h0000, 4'd0, 4'd0, 3'd4, 32'd0, 4'd3, 3'd6, 0, "R6");
    step(16'h0000, 4'd0, 4'd0, 3'd4, 32'd0, 4'd0, 3'd4, 1, "R7");
    step(16'h0000, 4'd0, 4'd0, 3'd4, 32'd0, 4'd0, 3'd2, 1, "R7");
    step(16'h0000, 4'd0, 4'd0, 3'd4, 32'd0, 4'd5, 3'd3, 1, "R7");
    step(16'hbeef, 4'd0, 4'd0, 3'd4, 32'd0, 4'd1, 3'd0, 1, "R8");
    step(16'h0f0f, 4'd12, 4'd8, 3'd4, 32'd0, 4'd1, 3'd0, 1, "R9");
    step(16'h0f0f, 4'd6, 4'd15, 3'd4, 32'd0, 4'd1, 3'd0, 1, "R9");
    step(16'h1111, 4'd9, 4'd9, 3'd4, 32'd0, 4'd1, 3'd4, 0, "R10");
    step(16'h2222, 4'd1, 4'd1, 3'd4, 32'd0, 4'd1, 3'd0, 0, "R10");
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] c = ($urandom_range(0, 7) == 0) ? $urandom() : 32'($urandom_range(0, 18));
      step(16'($urandom()), 4'($urandom_range(0, 15)) & {4{$urandom_range(0, 3) != 0}},
           4'($urandom_range(0, 15)) & {4{$urandom_range(0, 3) != 0}},
           3'($urandom_range(0, 7)), c, 4'($urandom_range(0, 15)) & {4{$urandom_range(0, 1) != 0}},
           3'($urandom_range(0, 7)), bit'($urandom_range(0, 1)), "R9");
    end
    step(16'h0000, 4'd0, 4'd0, 3'd4, 32'd0, 4'd1, 3'd0, 0, "R10");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule